// File: doc/BRIEF.md
# Bridge Driver Mode and Fault Supervisor

This block decides, on every clock, whether the two H-bridges of a stepper driver may conduct, whether the step indexer is held at home, whether step pulses are let through, and whether the charge pump and logic regulator run. It takes synchronous level inputs: an active-low sleep request, an active-low output enable, an active-low indexer reset, one overcurrent flag per bridge, an over-temperature flag and a supply-undervoltage flag. The analog comparators that raise these flags are outside the block.

Faults are handled in two ways. A per-bridge overcurrent flag must stay high for a programmable run of consecutive clocks before it trips. A trip is latched and shuts down all bridges until the indexer reset input is applied or the supply drops out. Over-temperature shuts the bridges down only while its flag is high. Undervoltage turns everything off and clears all internal state, and it does not drive the fault pin. After sleep or undervoltage ends, a wake timer keeps steps blocked for a programmable number of clocks.

The conditions are ranked, highest first: undervoltage, sleep, indexer reset, latched overcurrent, over-temperature, output enable.

Top module: `motor_drv_supervisor`

## Requirements
- R1: While `uv_i` is 1, all `bridge_en_o` bits are 0, `pump_en_o` and `step_ok_o` are 0, `idx_rst_o` is 1 and `fault_no` is 1. A clock edge with `uv_i` at 1 clears every latched overcurrent and restarts the wake timer.
- R2: While `uv_i` is 0 and `sleep_ni` is 0, the bridges, the pump, `step_ok_o` and `idx_rst_o` are all 0. `fault_no` is 0 only if an overcurrent latch is set. During sleep, `reset_ni` does not clear a latch, and overcurrent flags neither count nor trip.
- R3: `step_ok_o` can be 1 only after `WAKE_CYCLES` consecutive clock edges with `uv_i` at 0 and `sleep_ni` at 1. Any edge with sleep or undervoltage active restarts this count.
- R4: While awake with `reset_ni` at 1 and `enable_ni` at 1, the bridges are off and `step_ok_o` is 0, while `pump_en_o` stays 1.
- R5: While awake with `reset_ni` at 0, `idx_rst_o` is 1, the bridges are off and `step_ok_o` is 0. A clock edge in this state clears all overcurrent latches and deglitch counts.
- R6: An overcurrent flag trips its bridge's latch on the `OCP_CYCLES`-th consecutive edge at which the flag is seen high while awake and not in reset. A shorter run does not trip, and any edge with the flag low restarts the count.
- R7: While any overcurrent latch is set and the block is awake, `fault_no` is 0, all bridges are off and `step_ok_o` is 0. This lasts after the flag drops, through changes of `enable_ni` and through sleep, until R1 or R5 clears it.
- R8: While awake with `ot_i` at 1, `fault_no` is 0, the bridges are off and `step_ok_o` is 0. When `ot_i` returns to 0 with no other condition active, the bridges come back on in the same cycle and nothing is latched.
- R9: When awake, with `reset_ni` at 1, `enable_ni` at 0, no latch and `ot_i` at 0, every `bridge_en_o` bit is 1, `fault_no` is 1 and `step_ok_o` follows the wake-timer completion of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of all state |
| sleep_ni | input | 1 | Active-low sleep request |
| enable_ni | input | 1 | Active-low output enable |
| reset_ni | input | 1 | Active-low indexer reset and overcurrent-latch clear |
| ocp_i | input | NUM_BRIDGES | Per-bridge overcurrent flag |
| ot_i | input | 1 | Over-temperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| bridge_en_o | output | NUM_BRIDGES | Per-bridge drive enable |
| idx_rst_o | output | 1 | Hold step indexer at home |
| step_ok_o | output | 1 | Step pulses may be accepted |
| pump_en_o | output | 1 | Charge pump and regulator enable |
| fault_no | output | 1 | Active-low fault indicator |

## Verification
The bench sweeps the overcurrent run length on each bridge from one clock up to one past the trip count. An off-by-one deglitch would trip a clock early or late. A run broken by a single low clock must not trip, so a counter that does not restart would show a false fault. The bench checks that sleep neither clears a latch nor lets a flag count, and that the latch survives enable toggling. A design that tied the latch to the live flag, or let reset act during sleep, would clear the fault too early. All 32 combinations of the level inputs are applied with the latch both clear and set, which exposes any wrong ranking of the conditions. The wake gap is sampled on every clock after release from sleep and after an undervoltage pulse, so a timer that was off by one or did not restart would open `step_ok_o` at the wrong clock.

// File: rtl/motor_sup_pkg.sv
package motor_sup_pkg;
  typedef enum logic [2:0] {
    M_UV,
    M_SLEEP,
    M_RESET,
    M_OCP,
    M_THERM,
    M_OFF,
    M_RUN
  } sup_mode_e;
endpackage

// File: rtl/sup_wake_timer.sv
module sup_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (hold_i)      cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == TERM);
endmodule

// File: rtl/sup_ocp_guard.sv
module sup_ocp_guard #(
  parameter int unsigned OCP_CYCLES = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic freeze_i,
  input  logic flag_i,
  output logic latched_o
);
  localparam int unsigned CW = (OCP_CYCLES > 1) ? $clog2(OCP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(OCP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (freeze_i || lat_q || !flag_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lat_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign latched_o = lat_q;
endmodule

// File: rtl/sup_mode_arb.sv
module sup_mode_arb
  import motor_sup_pkg::*;
(
  input  logic      uv_i,
  input  logic      sleep_ni,
  input  logic      reset_ni,
  input  logic      ocp_lat_i,
  input  logic      ot_i,
  input  logic      enable_ni,
  input  logic      wake_done_i,
  output sup_mode_e mode_o,
  output logic      drive_o,
  output logic      step_ok_o,
  output logic      pump_en_o,
  output logic      idx_rst_o,
  output logic      fault_no
);
  always_comb begin
    if (uv_i)            mode_o = M_UV;
    else if (!sleep_ni)  mode_o = M_SLEEP;
    else if (!reset_ni)  mode_o = M_RESET;
    else if (ocp_lat_i)  mode_o = M_OCP;
    else if (ot_i)       mode_o = M_THERM;
    else if (enable_ni)  mode_o = M_OFF;
    else                 mode_o = M_RUN;
  end

  always_comb begin
    drive_o   = (mode_o == M_RUN);
    step_ok_o = drive_o && wake_done_i;
    pump_en_o = !(mode_o inside {M_UV, M_SLEEP});
    idx_rst_o = (mode_o inside {M_UV, M_RESET});
    // latch reported in sleep; thermal only when awake
    fault_no  = !((mode_o != M_UV) &&
                  (ocp_lat_i || ((mode_o != M_SLEEP) && ot_i)));
  end
endmodule

// File: rtl/motor_drv_supervisor.sv
module motor_drv_supervisor
  import motor_sup_pkg::*;
#(
  parameter int unsigned NUM_BRIDGES = 2,
  parameter int unsigned OCP_CYCLES  = 35,
  parameter int unsigned WAKE_CYCLES = 20000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sleep_ni,
  input  logic                   enable_ni,
  input  logic                   reset_ni,
  input  logic [NUM_BRIDGES-1:0] ocp_i,
  input  logic                   ot_i,
  input  logic                   uv_i,
  output logic [NUM_BRIDGES-1:0] bridge_en_o,
  output logic                   idx_rst_o,
  output logic                   step_ok_o,
  output logic                   pump_en_o,
  output logic                   fault_no
);
  logic                   awake;
  logic                   clr_lat;
  logic                   wake_done;
  logic                   drive;
  logic [NUM_BRIDGES-1:0] lat_vec;
  sup_mode_e              mode;

  assign awake   = !uv_i && sleep_ni;
  assign clr_lat = uv_i || (awake && !reset_ni);

  sup_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (!awake),
    .done_o (wake_done)
  );

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_ocp
    sup_ocp_guard #(.OCP_CYCLES(OCP_CYCLES)) u_guard (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_lat),
      .freeze_i  (!awake || !reset_ni),
      .flag_i    (ocp_i[b]),
      .latched_o (lat_vec[b])
    );
  end

  sup_mode_arb u_arb (
    .uv_i        (uv_i),
    .sleep_ni    (sleep_ni),
    .reset_ni    (reset_ni),
    .ocp_lat_i   (|lat_vec),
    .ot_i        (ot_i),
    .enable_ni   (enable_ni),
    .wake_done_i (wake_done),
    .mode_o      (mode),
    .drive_o     (drive),
    .step_ok_o   (step_ok_o),
    .pump_en_o   (pump_en_o),
    .idx_rst_o   (idx_rst_o),
    .fault_no    (fault_no)
  );

  assign bridge_en_o = {NUM_BRIDGES{drive}};
endmodule

// File: rtl/motor_sup_chk.sv
module motor_sup_chk #(
  parameter int unsigned NUM_BRIDGES = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sleep_ni,
  input logic                   enable_ni,
  input logic                   reset_ni,
  input logic                   ot_i,
  input logic                   uv_i,
  input logic [NUM_BRIDGES-1:0] bridge_en_o,
  input logic                   idx_rst_o,
  input logic                   step_ok_o,
  input logic                   pump_en_o,
  input logic                   fault_no
);
  p_uv_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> (bridge_en_o == '0 && !pump_en_o && idx_rst_o && fault_no));

  p_sleep_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uv_i && !sleep_ni) |-> (bridge_en_o == '0 && !pump_en_o && !step_ok_o && !idx_rst_o));

  p_wake_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i || !sleep_ni) |=> !step_ok_o);

  p_disable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uv_i && sleep_ni && enable_ni) |-> (bridge_en_o == '0 && !step_ok_o));

  p_idx_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uv_i && sleep_ni && !reset_ni) |-> (idx_rst_o && bridge_en_o == '0 && !step_ok_o));

  p_fault_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |-> (bridge_en_o == '0 && !step_ok_o));

  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uv_i && sleep_ni && reset_ni && !ot_i && !fault_no)
      |=> (uv_i || !sleep_ni || !fault_no));

  p_step_needs_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_ok_o |-> (&bridge_en_o));
endmodule

bind motor_drv_supervisor motor_sup_chk #(.NUM_BRIDGES(NUM_BRIDGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_ni    (sleep_ni),
  .enable_ni   (enable_ni),
  .reset_ni    (reset_ni),
  .ot_i        (ot_i),
  .uv_i        (uv_i),
  .bridge_en_o (bridge_en_o),
  .idx_rst_o   (idx_rst_o),
  .step_ok_o   (step_ok_o),
  .pump_en_o   (pump_en_o),
  .fault_no    (fault_no)
);

// File: tb/motor_drv_supervisor_tb.sv
module motor_drv_supervisor_tb;
  localparam int NB = 2;
  localparam int OCP = 4;
  localparam int WAKE = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_ni = 1'b0, enable_ni = 1'b1, reset_ni = 1'b1, ot_i = 1'b0, uv_i = 1'b0;
  logic [NB-1:0] ocp_i = '0;
  logic [NB-1:0] bridge_en_o;
  logic idx_rst_o, step_ok_o, pump_en_o, fault_no;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  motor_drv_supervisor #(.NUM_BRIDGES(NB), .OCP_CYCLES(OCP), .WAKE_CYCLES(WAKE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_ni(sleep_ni), .enable_ni(enable_ni),
    .reset_ni(reset_ni), .ocp_i(ocp_i), .ot_i(ot_i), .uv_i(uv_i),
    .bridge_en_o(bridge_en_o), .idx_rst_o(idx_rst_o), .step_ok_o(step_ok_o),
    .pump_en_o(pump_en_o), .fault_no(fault_no)
  );

  // packed view: {bridge_en[1:0], step_ok, pump_en, idx_rst, fault_n}
  function automatic logic [5:0] expect_out(logic uv, logic sl_n, logic rs_n, logic ot,
                                            logic en_n, logic lat, logic wdone);
    logic awake, run;
    awake = !uv && sl_n;
    run = awake && rs_n && !lat && !ot && !en_n;
    return {{2{run}}, run && wdone, awake, uv || (awake && !rs_n),
            !(!uv && ((sl_n && ot) || lat))};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] obs();
    return {bridge_en_o, step_ok_o, pump_en_o, idx_rst_o, fault_no};
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // inputs go to the running state
  task automatic set_run();
    uv_i = 0; sleep_ni = 1; reset_ni = 1; ot_i = 0; enable_ni = 0; ocp_i = '0;
  endtask

  task automatic sweep_combos(input string req, input logic lat);
    for (int c = 0; c < 32; c++) begin
      cyc(1);
      {uv_i, sleep_ni, reset_ni, ot_i, enable_ni} = 5'(c);
      #1;
      check(req, obs(), expect_out(uv_i, sleep_ni, reset_ni, ot_i, enable_ni, lat, 1'b1));
      set_run();
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state, asleep
    cyc(3);
    check("R2 reset state", obs(), 6'b000001);
    rst_ni = 1'b1;
    cyc(2);
    check("R2 asleep after reset", obs(), 6'b000001);

    // R3: wake gap after sleep release
    set_run();
    for (int k = 0; k <= WAKE + 1; k++) begin
      #1;
      check("R3 wake gap", obs(), expect_out(0, 1, 1, 0, 0, 0, k >= WAKE));
      cyc(1);
    end
    check("R9 run", obs(), 6'b111101);

    // R1/R3: undervoltage pulse restarts the wake timer
    uv_i = 1; #1;
    check("R1 uv outputs", obs(), 6'b000011);
    cyc(1);
    uv_i = 0;
    for (int k = 0; k <= WAKE; k++) begin
      #1;
      check_bit("R3 uv restart", step_ok_o, k >= WAKE);
      cyc(1);
    end

    // R6/R7: run-length sweep per bridge
    for (int b = 0; b < NB; b++) begin
      for (int len = 1; len <= OCP + 1; len++) begin
        ocp_i[b] = 1'b1;
        cyc(len);
        ocp_i[b] = 1'b0;
        #1;
        check_bit("R6 trip length", fault_no, !(len >= OCP));
        if (len >= OCP) begin
          enable_ni = 1; cyc(2); enable_ni = 0; cyc(2);
          check("R7 latch held", obs(), 6'b000100);
          reset_ni = 0; cyc(1); reset_ni = 1; #1;
          check("R5 reset clears latch", obs(), 6'b111101);
        end
        cyc(1);
      end
    end

    // R6: one low clock restarts the count
    ocp_i[1] = 1; cyc(OCP - 1); ocp_i[1] = 0; cyc(1);
    ocp_i[1] = 1; cyc(OCP - 1); ocp_i[1] = 0; #1;
    check_bit("R6 broken run", fault_no, 1'b1);

    // R2: flags ignored in sleep
    cyc(1);
    sleep_ni = 0; ocp_i = '1; cyc(OCP + 2);
    sleep_ni = 1; ocp_i = '0; #1;
    check_bit("R2 no trip asleep", fault_no, 1'b1);
    cyc(WAKE + 1);
    check("R9 rewoken", obs(), 6'b111101);

    // R7: latch survives sleep and reset during sleep; uv clears it
    ocp_i[0] = 1; cyc(OCP); ocp_i[0] = 0; #1;
    check_bit("R7 tripped", fault_no, 1'b0);
    sleep_ni = 0; reset_ni = 0; #1;
    check("R2 latch shown asleep", obs(), 6'b000000);
    cyc(3);
    sleep_ni = 1; reset_ni = 1; cyc(WAKE + 1);
    check("R7 latch after sleep", obs(), 6'b000100);

    // exhaustive ranking with latch set
    sweep_combos("R7 ranking latched", 1'b1);

    uv_i = 1; cyc(1); uv_i = 0; #1;
    check("R1 uv clears latch", obs(), 6'b110101);
    cyc(WAKE + 1);

    // R8: thermal self-clears
    ot_i = 1; #1;
    check("R8 thermal", obs(), 6'b000100);
    cyc(4);
    check("R8 thermal held", obs(), 6'b000100);
    ot_i = 0; #1;
    check("R8 thermal recovers", obs(), 6'b111101);

    // R4: enable off
    enable_ni = 1; #1;
    check("R4 disabled", obs(), 6'b000101);
    cyc(1);
    set_run();

    // exhaustive ranking, latch clear
    sweep_combos("R9 ranking clear", 1'b0);

    cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule